// File: doc/BRIEF.md
# Reset Mode Select and Serial Bootstrap Loader

This block decides how a small controller starts after reset. While reset is held it samples two strap pins. The value captured at the last clock edge of reset becomes the operating mode. That mode stays fixed until the next reset, whatever the pins do afterwards. From the mode the block derives three things: an enable for the external multiplexed bus, a start address for the CPU, and the moment the CPU may begin fetching.

In the bootstrap mode the CPU is held. The block takes a stream of bytes from a UART receiver, presented as a one-cycle valid strobe with a data byte. It writes each byte into RAM at consecutive addresses starting at `0x0000`. When the last byte of a fixed-length image has been stored, the CPU is released at `0x0000`. In every other mode the CPU is released on the first clock edge after reset, with a start address of `0xE000`.

The sequencer has three states:
- `ST_HOLD` is the reset state.
- `ST_HOLD` goes to `ST_LOAD` through the transition *enter_load*, taken on the first edge out of reset in bootstrap mode.
- `ST_HOLD` goes to `ST_RUN` through *skip_load*, taken on that same edge in any other mode.
- `ST_LOAD` goes to `ST_RUN` through *image_done*, taken on the edge that stores the final byte.
- `ST_RUN` holds until reset.

Top module: `boot_mode_ctrl`

## Requirements
- R1: `mode_o` equals {`mode_a_i`, `mode_b_i`} as sampled on the last rising edge at which `rst_n` is low, and it does not change while `rst_n` stays high, whatever the pins do.
- R2: Mode encoding on `mode_o` is: 2'b00 bootstrap, 2'b01 single-chip, 2'b11 expanded, 2'b10 special test.
- R3: `bus_en_o` is high in expanded (11) and special test (10) modes, and low in single-chip (01) and bootstrap (00) modes.
- R4: `start_addr_o` is 16'h0000 in bootstrap mode and 16'hE000 in the other three modes.
- R5: In non-bootstrap modes `cpu_release_o` is low during reset and rises on the first rising edge at which `rst_n` is high.
- R6: While loading, each cycle with `rx_valid_i` high drives `ram_we_o` high in that same cycle, with `ram_data_o` equal to `rx_data_i` and `ram_addr_o` equal to 16'h0000 plus the number of bytes already accepted.
- R7: In bootstrap mode `cpu_release_o` stays low until the edge that stores byte 256 (the byte at address 16'h00FF), and it is high from that edge on.
- R8: Bytes presented after the 256th byte produce no write: `ram_we_o` stays low.
- R9: In non-bootstrap modes, and during reset or the first cycle after it, `rx_valid_i` never causes a write.
- R10: Cycles without `rx_valid_i` while loading write nothing and do not advance the RAM address.
- R11: Once high, `cpu_release_o` stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_a_i | input | 1 | First strap pin (upper bit of mode) |
| mode_b_i | input | 1 | Second strap pin (lower bit of mode) |
| rx_valid_i | input | 1 | One-cycle strobe: a received byte is present |
| rx_data_i | input | 8 | Received byte |
| mode_o | output | 2 | Latched operating mode |
| bus_en_o | output | 1 | External multiplexed bus enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 16 | RAM write address |
| ram_data_o | output | 8 | RAM write data |
| start_addr_o | output | 16 | CPU start address |
| cpu_release_o | output | 1 | CPU may begin execution |

## Verification
The bench changes the strap pins in the same cycle that reset is released, and again later. A design that latched the pins on the wrong edge, or kept sampling them after reset, would report a changed mode. In bootstrap mode it feeds all 256 bytes with random data and random idle gaps. A counter that advanced on idle cycles would skip addresses, and one that ended one byte early or late would release the CPU at the wrong edge. After the image, and in every other mode, it keeps presenting bytes. A loader that did not close its write port would overwrite RAM past the image, or would write while the CPU runs.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

    localparam logic [1:0] MODE_BOOT   = 2'b00;
    localparam logic [1:0] MODE_SINGLE = 2'b01;
    localparam logic [1:0] MODE_TEST   = 2'b10;
    localparam logic [1:0] MODE_EXPAND = 2'b11;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } boot_state_t;

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import boot_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_a,
    input  logic       pin_b,
    output logic [1:0] mode,
    output logic       is_boot,
    output logic       bus_en
);

    // Follow the pins throughout reset; freeze once reset is gone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= {pin_a, pin_b};
        end
    end

    always_comb begin
        is_boot = (mode == MODE_BOOT);
        bus_en  = (mode == MODE_EXPAND) || (mode == MODE_TEST);
    end

endmodule

// File: rtl/image_counter.sv
module image_counter #(
    parameter int CNT_W = 8,
    parameter int LAST  = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             at_last
);

    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    assign at_last = (count == LAST_V);

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import boot_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic is_boot,
    input  logic rx_valid,
    input  logic at_last,
    output logic wr_en,
    output logic release_cpu
);

    boot_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = is_boot ? ST_LOAD : ST_RUN;       // enter_load / skip_load
            ST_LOAD: if (rx_valid && at_last) state_d = ST_RUN;  // image_done
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        wr_en       = 1'b0;
        release_cpu = 1'b0;
        unique case (state_q)
            ST_HOLD: ;
            ST_LOAD: wr_en = rx_valid;
            ST_RUN:  release_cpu = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl #(
    parameter int              ADDR_W     = 16,
    parameter int              DATA_W     = 8,
    parameter int              IMAGE_LEN  = 256,
    parameter logic [15:0]     LOAD_BASE  = 16'h0000,
    parameter logic [15:0]     RESET_VEC  = 16'hE000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_a_i,
    input  logic              mode_b_i,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic [1:0]        mode_o,
    output logic              bus_en_o,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_data_o,
    output logic [ADDR_W-1:0] start_addr_o,
    output logic              cpu_release_o
);

    localparam int CNT_W = (IMAGE_LEN > 1) ? $clog2(IMAGE_LEN) : 1;

    logic             is_boot;
    logic [CNT_W-1:0] count;
    logic             at_last;
    logic             wr_en;

    strap_latch u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_a   (mode_a_i),
        .pin_b   (mode_b_i),
        .mode    (mode_o),
        .is_boot (is_boot),
        .bus_en  (bus_en_o)
    );

    image_counter #(
        .CNT_W (CNT_W),
        .LAST  (IMAGE_LEN - 1)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (wr_en),
        .count   (count),
        .at_last (at_last)
    );

    boot_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_boot     (is_boot),
        .rx_valid    (rx_valid_i),
        .at_last     (at_last),
        .wr_en       (wr_en),
        .release_cpu (cpu_release_o)
    );

    assign ram_we_o     = wr_en;
    assign ram_addr_o   = ADDR_W'(LOAD_BASE) + ADDR_W'(count);
    assign ram_data_o   = rx_data_i;
    assign start_addr_o = is_boot ? ADDR_W'(LOAD_BASE) : ADDR_W'(RESET_VEC);

endmodule

// File: rtl/boot_mode_ctrl_chk.sv
module boot_mode_ctrl_chk #(
    parameter int          ADDR_W    = 16,
    parameter int          IMAGE_LEN = 256,
    parameter logic [15:0] LOAD_BASE = 16'h0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_o,
    input logic              bus_en_o,
    input logic              ram_we_o,
    input logic [ADDR_W-1:0] ram_addr_o,
    input logic              cpu_release_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(LOAD_BASE) + ADDR_W'(IMAGE_LEN - 1);

    assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_o));

    assert_single_no_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01) |-> !bus_en_o);

    assert_write_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_addr_o - ADDR_W'(LOAD_BASE)) < ADDR_W'(IMAGE_LEN));

    assert_boot_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_release_o) && mode_o == 2'b00) |-> ($past(ram_we_o) && $past(ram_addr_o) == LAST_ADDR));

    assert_no_write_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_release_o |-> !ram_we_o);

    assert_no_write_other_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b00) |-> !ram_we_o);

    assert_release_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpu_release_o) |-> cpu_release_o);

endmodule

bind boot_mode_ctrl boot_mode_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .IMAGE_LEN (IMAGE_LEN),
    .LOAD_BASE (LOAD_BASE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_o        (mode_o),
    .bus_en_o      (bus_en_o),
    .ram_we_o      (ram_we_o),
    .ram_addr_o    (ram_addr_o),
    .cpu_release_o (cpu_release_o)
);

// File: tb/boot_mode_ctrl_bench.sv
module boot_mode_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_a = 1'b0;
    logic        mode_b = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [1:0]  mode_o;
    logic        bus_en;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_data;
    logic [15:0] start_addr;
    logic        cpu_release;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    boot_mode_ctrl u_boot_mode_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_a_i      (mode_a),
        .mode_b_i      (mode_b),
        .rx_valid_i    (rx_valid),
        .rx_data_i     (rx_data),
        .mode_o        (mode_o),
        .bus_en_o      (bus_en),
        .ram_we_o      (ram_we),
        .ram_addr_o    (ram_addr),
        .ram_data_o    (ram_data),
        .start_addr_o  (start_addr),
        .cpu_release_o (cpu_release)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_bus(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic [15:0] exp_start(input logic [1:0] m);
        return (m == 2'b00) ? 16'h0000 : 16'hE000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Hold reset with the given pins, release it and scramble the pins.
    task automatic apply_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; rx_valid = 1'b0;
        mode_a = m[1]; mode_b = m[0];
        repeat (3) @(negedge clk);
        #1;
        chk(cpu_release == 1'b0, "R5 release low in reset", 32'(cpu_release), 0);
        chk(ram_we == 1'b0, "R9 no write in reset", 32'(ram_we), 0);
        @(negedge clk);
        rst_n = 1'b1;
        mode_a = ~m[1]; mode_b = ~m[0];
        rx_valid = 1'b1; rx_data = 8'h5A;
        #1;
        chk(mode_o == m, "R1 mode latched", 32'(mode_o), 32'(m));
        chk(cpu_release == 1'b0, "R5 release low first cycle", 32'(cpu_release), 0);
        chk(ram_we == 1'b0, "R9 no write first cycle", 32'(ram_we), 0);
    endtask

    task automatic run_other(input logic [1:0] m);
        apply_reset(m);
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
        chk(cpu_release == 1'b1, "R5 release after one edge", 32'(cpu_release), 1);
        chk(bus_en == exp_bus(m), "R3 bus enable", 32'(bus_en), 32'(exp_bus(m)));
        chk(start_addr == exp_start(m), "R4 start address", 32'(start_addr), 32'(exp_start(m)));
        chk(mode_o == m, "R2 mode code", 32'(mode_o), 32'(m));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'($urandom);
            mode_a = 1'($urandom); mode_b = 1'($urandom);
            #1;
            chk(ram_we == 1'b0, "R9 no write in other mode", 32'(ram_we), 0);
            chk(cpu_release == 1'b1, "R11 release sticky", 32'(cpu_release), 1);
            chk(mode_o == m, "R1 mode frozen", 32'(mode_o), 32'(m));
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic run_boot();
        apply_reset(2'b00);
        chk(bus_en == 1'b0, "R3 no bus in bootstrap", 32'(bus_en), 0);
        chk(start_addr == 16'h0000, "R4 boot start address", 32'(start_addr), 0);
        for (int n = 0; n < 256; n++) begin
            int gaps = (($urandom % 4) == 0) ? int'($urandom % 3) + 1 : 0;
            for (int g = 0; g < gaps; g++) begin
                @(negedge clk);
                rx_valid = 1'b0;
                #1;
                chk(ram_we == 1'b0, "R10 no write on idle", 32'(ram_we), 0);
                chk(ram_addr == 16'(n), "R10 address holds", 32'(ram_addr), 32'(n));
            end
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data = (n == 0) ? 8'h00 : (n == 255) ? 8'hFF : 8'($urandom);
            #1;
            chk(ram_we == 1'b1, "R6 write strobe", 32'(ram_we), 1);
            chk(ram_addr == 16'(n), "R6 write address", 32'(ram_addr), 32'(n));
            chk(ram_data == rx_data, "R6 write data", 32'(ram_data), 32'(rx_data));
            chk(cpu_release == 1'b0, "R7 held while loading", 32'(cpu_release), 0);
            chk(mode_o == 2'b00, "R1 mode frozen during load", 32'(mode_o), 0);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
        chk(cpu_release == 1'b1, "R7 release after byte 256", 32'(cpu_release), 1);
        chk(start_addr == 16'h0000, "R4 boot start after load", 32'(start_addr), 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'($urandom);
            #1;
            chk(ram_we == 1'b0, "R8 extra byte ignored", 32'(ram_we), 0);
            chk(cpu_release == 1'b1, "R11 release sticky", 32'(cpu_release), 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240607));
        run_other(2'b01);
        run_other(2'b11);
        run_other(2'b10);
        run_boot();
        for (int k = 0; k < 3; k++) begin
            logic [1:0] m = 2'($urandom);
            if (m == 2'b00) run_boot(); else run_other(m);
        end
        run_boot();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule